// File: doc/BRIEF.md
# Survivor Path Metric Selector

This block sits after the metric computation stage of a list decoder for polar codes. At each decoding step every one of the `LIST` current paths branches into `2**PAT_W` candidates. The block receives the full-width signed metric of every candidate and chooses the `LIST` candidates with the largest metrics as the next set of surviving paths. A larger metric means a more likely path.

To keep the comparator chain short, every comparison uses a copy of the metric that is one bit narrower. That copy is the metric with its least significant bit dropped by an arithmetic shift. The metric reported for each survivor is still the full-width value. A candidate that an earlier stage has ruled out carries the most negative code. Such a candidate ranks below every valid candidate.

The caller holds the candidate vector stable and pulses `start`. The block then picks one survivor per cycle, best first, and raises `done` for one cycle once all `LIST` slots are filled. Each slot gives the parent path, the branch pattern and the full metric of one survivor.

Top module: `pm_survivor_select`

## Requirements
- R1: After reset `done` is low and every survivor output field is zero.
- R2: `done` goes high for exactly one cycle. It does so at the `LIST`-th rising edge after the edge that samples `start` high while the block is idle. With defaults, `done` is seen in the 5th cycle counted from the cycle in which `start` is driven.
- R3: Slot 0 holds the candidate with the largest truncated metric, `metric >>> 1`, signed. Each later slot holds the best candidate among those not yet chosen. Slots therefore appear in non-increasing truncated-metric order, and no candidate appears twice.
- R4: Candidates with equal truncated metrics rank by flat index, lowest first. This holds even when their full metrics differ in the least significant bit.
- R5: Each slot's metric output equals the chosen candidate's full `MET_W`-bit input metric, unchanged.
- R6: A candidate whose metric is the most negative code (0x80 for 8 bits) is invalid. An invalid candidate is never chosen while an unchosen valid candidate remains. A valid metric of -127 therefore outranks an invalid candidate, even though both truncate to -64.
- R7: Candidate flat index `c` occupies bits `[c*MET_W +: MET_W]` of `cand_metric`. Its parent is `c / 2**PAT_W` and its pattern is `c % 2**PAT_W`. Slot `s` occupies field `s` of each output vector, with slot 0 as the least significant field.
- R8: A `start` pulse while a selection is running is ignored. `done` is still raised exactly once for the run that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a selection over the current candidate vector |
| cand_metric | input | LIST*2**PAT_W*MET_W | Signed candidate metrics, flat index order |
| done | output | 1 | One-cycle pulse when all survivors are written |
| surv_parent | output | LIST*$clog2(LIST) | Parent path index per slot |
| surv_pattern | output | LIST*PAT_W | Branch pattern per slot |
| surv_metric | output | LIST*MET_W | Full-width metric per slot |

## Verification
The assertions assume that `cand_metric` holds still from `start` until `done`. Under that assumption, the best candidate found in one cycle can never beat the candidate chosen in the previous cycle. The stimulus writes a new candidate vector only while the block is idle, between runs.

Random vectors are drawn from a narrow value range so that truncated ties occur often. Invalid codes are mixed into those vectors. Directed vectors cover three cases:
- every candidate equal;
- a pair of candidates that differ only in the least significant bit;
- a -127 candidate set against a field of invalid candidates.

// File: rtl/pm_sel_pkg.sv
package pm_sel_pkg;
  typedef enum logic {SEL_IDLE = 1'b0, SEL_RUN = 1'b1} sel_state_t;
endpackage

// File: rtl/pm_rank_cmp.sv
module pm_rank_cmp #(
  parameter int KEY_W = 7,
  parameter int IDX_W = 6
) (
  input  logic             a_elig,
  input  logic             a_valid,
  input  logic [KEY_W-1:0] a_key,
  input  logic [IDX_W-1:0] a_idx,
  input  logic             b_elig,
  input  logic             b_valid,
  input  logic [KEY_W-1:0] b_key,
  input  logic [IDX_W-1:0] b_idx,
  output logic             w_elig,
  output logic             w_valid,
  output logic [KEY_W-1:0] w_key,
  output logic [IDX_W-1:0] w_idx
);
  logic a_wins;

  always_comb begin
    if (a_elig != b_elig)             a_wins = a_elig;
    else if (a_valid != b_valid)      a_wins = a_valid;
    else if (a_key != b_key)          a_wins = $signed(a_key) > $signed(b_key);
    else                              a_wins = a_idx < b_idx;
  end

  assign w_elig  = a_wins ? a_elig  : b_elig;
  assign w_valid = a_wins ? a_valid : b_valid;
  assign w_key   = a_wins ? a_key   : b_key;
  assign w_idx   = a_wins ? a_idx   : b_idx;
endmodule

// File: rtl/pm_argmax_tree.sv
module pm_argmax_tree #(
  parameter int NCAND = 64,
  parameter int MET_W = 8,
  localparam int KEY_W = MET_W - 1,
  localparam int IDX_W = $clog2(NCAND),
  localparam int NODES = 2 * NCAND - 1
) (
  input  logic [NCAND*MET_W-1:0] metric,
  input  logic [NCAND-1:0]       taken,
  output logic                   win_elig,
  output logic                   win_valid,
  output logic [KEY_W-1:0]       win_key,
  output logic [IDX_W-1:0]       win_idx
);
  logic             n_elig  [NODES];
  logic             n_valid [NODES];
  logic [KEY_W-1:0] n_key   [NODES];
  logic [IDX_W-1:0] n_idx   [NODES];

  localparam logic [MET_W-1:0] NEG_INF = {1'b1, {(MET_W-1){1'b0}}};

  for (genvar i = 0; i < NCAND; i++) begin : g_leaf
    assign n_elig [NCAND-1+i] = ~taken[i];
    assign n_valid[NCAND-1+i] = metric[i*MET_W +: MET_W] != NEG_INF;
    assign n_key  [NCAND-1+i] = metric[i*MET_W+1 +: KEY_W];
    assign n_idx  [NCAND-1+i] = IDX_W'(i);
  end

  for (genvar n = 0; n < NCAND - 1; n++) begin : g_node
    pm_rank_cmp #(.KEY_W(KEY_W), .IDX_W(IDX_W)) i_cmp (
      .a_elig (n_elig [2*n+1]), .a_valid(n_valid[2*n+1]),
      .a_key  (n_key  [2*n+1]), .a_idx  (n_idx  [2*n+1]),
      .b_elig (n_elig [2*n+2]), .b_valid(n_valid[2*n+2]),
      .b_key  (n_key  [2*n+2]), .b_idx  (n_idx  [2*n+2]),
      .w_elig (n_elig [n]),     .w_valid(n_valid[n]),
      .w_key  (n_key  [n]),     .w_idx  (n_idx  [n])
    );
  end

  assign win_elig  = n_elig[0];
  assign win_valid = n_valid[0];
  assign win_key   = n_key[0];
  assign win_idx   = n_idx[0];
endmodule

// File: rtl/pm_survivor_select.sv
module pm_survivor_select
  import pm_sel_pkg::*;
#(
  parameter int LIST  = 4,
  parameter int PAT_W = 4,
  parameter int MET_W = 8,
  localparam int NCAND = LIST * (2 ** PAT_W),
  localparam int IDX_W = $clog2(NCAND),
  localparam int PAR_W = $clog2(LIST),
  localparam int KEY_W = MET_W - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [NCAND*MET_W-1:0] cand_metric,
  output logic                   done,
  output logic [LIST*PAR_W-1:0]  surv_parent,
  output logic [LIST*PAT_W-1:0]  surv_pattern,
  output logic [LIST*MET_W-1:0]  surv_metric
);
  localparam logic [MET_W-1:0] NEG_INF = {1'b1, {(MET_W-1){1'b0}}};

  sel_state_t       state;
  logic [PAR_W-1:0] pass;
  logic [NCAND-1:0] taken;
  logic             win_elig, win_valid;
  logic [KEY_W-1:0] win_key;
  logic [IDX_W-1:0] win_idx;
  logic [MET_W-1:0] win_metric;
  logic             last_valid;
  logic [KEY_W-1:0] last_key;

  pm_argmax_tree #(.NCAND(NCAND), .MET_W(MET_W)) i_tree (
    .metric   (cand_metric),
    .taken    (taken),
    .win_elig (win_elig),
    .win_valid(win_valid),
    .win_key  (win_key),
    .win_idx  (win_idx)
  );

  assign win_metric = cand_metric[win_idx*MET_W +: MET_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SEL_IDLE;
      pass         <= '0;
      taken        <= '0;
      done         <= 1'b0;
      last_valid   <= 1'b0;
      last_key     <= '0;
      surv_parent  <= '0;
      surv_pattern <= '0;
      surv_metric  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        SEL_IDLE: if (start) begin
          state <= SEL_RUN;
          pass  <= '0;
          taken <= '0;
        end
        SEL_RUN: begin
          surv_parent [pass*PAR_W +: PAR_W] <= win_idx[IDX_W-1:PAT_W];
          surv_pattern[pass*PAT_W +: PAT_W] <= win_idx[PAT_W-1:0];
          surv_metric [pass*MET_W +: MET_W] <= win_metric;
          taken[win_idx] <= 1'b1;
          last_valid     <= win_valid;
          last_key       <= win_key;
          if (pass == PAR_W'(LIST - 1)) begin
            state <= SEL_IDLE;
            done  <= 1'b1;
          end else begin
            pass <= pass + 1'b1;
          end
        end
        default: state <= SEL_IDLE;
      endcase
    end
  end

  // Valid, unchosen candidates still present (independent of the tree)
  logic valid_left;
  always_comb begin
    valid_left = 1'b0;
    for (int i = 0; i < NCAND; i++)
      if (!taken[i] && cand_metric[i*MET_W +: MET_W] != NEG_INF) valid_left = 1'b1;
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (state == SEL_RUN && pass != PAR_W'(LIST - 1)) |=> (state == SEL_RUN && !done));

  assert_fresh_pick_R3: assert property (@(posedge clk) disable iff (rst)
    (state == SEL_RUN) |-> !taken[win_idx]);

  assert_order_R3: assert property (@(posedge clk) disable iff (rst)
    (state == SEL_RUN && pass != '0 && win_valid && last_valid)
      |-> ($signed(win_key) <= $signed(last_key)));

  assert_invalid_last_R6: assert property (@(posedge clk) disable iff (rst)
    (state == SEL_RUN && !win_valid) |-> !valid_left);
endmodule

// File: tb/test_pm_survivor_select.sv
module test_pm_survivor_select;
  localparam int LIST = 4, PAT_W = 4, MET_W = 8;
  localparam int NCAND = LIST * (2 ** PAT_W);
  localparam int PAR_W = $clog2(LIST);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [NCAND*MET_W-1:0] cand_metric = '0;
  logic done;
  logic [LIST*PAR_W-1:0] surv_parent;
  logic [LIST*PAT_W-1:0] surv_pattern;
  logic [LIST*MET_W-1:0] surv_metric;

  int total = 0, bad = 0;
  logic [7:0] m [NCAND];
  int exp_idx [LIST];

  always #2 clk = ~clk;

  pm_survivor_select #(.LIST(LIST), .PAT_W(PAT_W), .MET_W(MET_W)) i_pm_survivor_select (
    .clk(clk), .rst(rst), .start(start), .cand_metric(cand_metric), .done(done),
    .surv_parent(surv_parent), .surv_pattern(surv_pattern), .surv_metric(surv_metric));

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic bit ranks_above(input int a, input int b);
    bit va = m[a] != 8'h80, vb = m[b] != 8'h80;
    int ka = $signed(m[a]) >>> 1, kb = $signed(m[b]) >>> 1;
    if (va != vb) return va;
    if (ka != kb) return ka > kb;
    return a < b;
  endfunction

  task automatic model();
    bit used [NCAND];
    for (int i = 0; i < NCAND; i++) used[i] = 1'b0;
    for (int s = 0; s < LIST; s++) begin
      int best = -1;
      for (int i = 0; i < NCAND; i++)
        if (!used[i] && (best < 0 || ranks_above(i, best))) best = i;
      exp_idx[s] = best;
      used[best] = 1'b1;
    end
  endtask

  task automatic run(input string tag, input int start_len);
    int cnt = 0;
    for (int i = 0; i < NCAND; i++) cand_metric[i*MET_W +: MET_W] = m[i];
    model();
    @(negedge clk); start = 1'b1;
    repeat (start_len) @(negedge clk);
    start = 1'b0;
    cnt = start_len;
    while (!done && cnt < 50) begin @(negedge clk); cnt++; end
    check({tag, " R2 done latency"}, cnt, LIST + 1);
    for (int s = 0; s < LIST; s++) begin
      int e = exp_idx[s];
      check({tag, " R3/R4/R6 parent R7"}, int'(surv_parent[s*PAR_W +: PAR_W]), e / (2 ** PAT_W));
      check({tag, " R3/R4/R6 pattern R7"}, int'(surv_pattern[s*PAT_W +: PAT_W]), e % (2 ** PAT_W));
      check({tag, " R5 metric"}, int'(surv_metric[s*MET_W +: MET_W]), int'(m[e]));
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check({tag, " R2 R8 single done"}, int'(done), 0);
    end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expected=done actual=hung");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done reset", int'(done), 0);
    check("R1 parent reset", int'(surv_parent), 0);
    check("R1 pattern reset", int'(surv_pattern), 0);
    check("R1 metric reset", int'(surv_metric), 0);

    // R4: all equal -> indices 0..3
    for (int i = 0; i < NCAND; i++) m[i] = 8'd20;
    run("all-equal", 1);

    // R4: LSB-only difference, lower index wins despite smaller full metric
    for (int i = 0; i < NCAND; i++) m[i] = 8'hF0;
    m[5] = 8'd40; m[9] = 8'd41; m[30] = 8'd41; m[60] = 8'd40;
    run("lsb-tie", 1);

    // R6: -127 versus invalid field
    for (int i = 0; i < NCAND; i++) m[i] = 8'h80;
    m[50] = 8'h81; m[63] = 8'h81;
    run("invalid", 1);

    // R8: start held high while busy
    for (int i = 0; i < NCAND; i++) m[i] = 8'($urandom_range(0, 255));
    run("busy-start R8", 4);

    // Random, narrow range for ties, with invalid codes mixed in
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < NCAND; i++) begin
        int r = $urandom_range(0, 9);
        m[i] = (r == 0) ? 8'h80 : 8'($signed($urandom_range(0, 15)) - 8);
      end
      run("random", 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule